// File: doc/BRIEF.md
# Preloaded Counter Clock Divider

This block turns a fast system clock into a square wave at one twentieth of its rate. A 4-bit synchronous counter steps through ten states. It starts from a preload value of 0011 and counts up to a terminal value of 1100. On the clock after it sits at 1100, it reloads 0011 instead of incrementing.

A decoder watches the three low counter bits. It raises a one-clock pulse while the counter holds 0111. That pulse drives a JK-style flip-flop wired so that each pulse toggles it, and it holds its value between pulses. Each counter pass of ten clocks therefore gives one half period of the output.

The preload value, terminal value, decode width and decode value are parameters, checked at elaboration. The divided clock, the decode pulse and the raw counter value are all brought out.

Top module: `pcd_divider`

## Requirements
- R1: While the counter is not at 1100, each rising clock edge increments it by one, wrapping 1111 to 0000.
- R2: On the rising edge after the counter holds 1100, it takes the value 0011.
- R3: After reset the counter repeats the ten-state sequence 0011, 0100, …, 1100, so each value recurs every 10 clocks.
- R4: Without any reset, the counter enters the range 0011..1100 from any start value within 16 clocks, and then follows R3.
- R5: `dec_pulse_o` is high exactly while the low three counter bits equal 111. Within the 0011..1100 range this happens only at 0111, for exactly one clock per pass.
- R6: On the rising edge after a cycle with `dec_pulse_o` high, `div_clk_o` inverts.
- R7: On the rising edge after a cycle with `dec_pulse_o` low, `div_clk_o` keeps its value.
- R8: A rising edge with `rst` high sets the counter to 0011 and `div_clk_o` low, so `dec_pulse_o` is low.
- R9: After reset is released, `div_clk_o` first rises on the 5th rising edge. It then has a period of 20 clocks.
- R10: Every 20-clock window of `div_clk_o` that starts at a rising edge holds exactly 10 high and 10 low cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| div_clk_o | output | 1 | Divided clock, one twentieth of clk |
| dec_pulse_o | output | 1 | One-clock decode pulse at count 0111 |
| count_o | output | CNT_W (4) | Current counter value |

## Verification
The counter and flip-flop are registers, so the counter value changes one edge after the state that caused it. The pulse is a combinational decode of the counter and is valid in the same cycle. The divided clock changes one edge after the pulse. The bench counts the rising edges since reset release and samples on the falling edge. It compares against closed forms: count = 3 + (n mod 10), pulse = (count == 7), and divided clock = floor((n+5)/10) mod 2. A second instance that is never reset is checked for entry into range within 16 edges and for correct succession afterwards.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
   typedef enum logic {
      PCD_MODE_COUNT = 1'b0,
      PCD_MODE_LOAD  = 1'b1
   } pcd_mode_e;

   typedef enum logic {
      PCD_DEC_FULL = 1'b0,
      PCD_DEC_LOW  = 1'b1
   } pcd_dec_kind_e;
endpackage

// File: rtl/pcd_counter.sv
module pcd_counter
   import pcd_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int LOAD_VAL = 3,
   parameter int TERM_VAL = 12
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LOAD_C = LOAD_VAL[CNT_W-1:0];
   localparam logic [CNT_W-1:0] TERM_C = TERM_VAL[CNT_W-1:0];

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   pcd_mode_e        mode;

   always_comb begin
      mode = (cnt_q == TERM_C) ? PCD_MODE_LOAD : PCD_MODE_COUNT;
      unique case (mode)
         PCD_MODE_LOAD:  cnt_d = LOAD_C;
         default:        cnt_d = cnt_q + 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= LOAD_C;
      else     cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/pcd_decode.sv
module pcd_decode
   import pcd_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int DEC_BITS = 3,
   parameter int DEC_VAL  = 7
) (
   input  logic [CNT_W-1:0] cnt_i,
   output logic             hit_o
);
   localparam pcd_dec_kind_e KIND = (DEC_BITS == CNT_W) ? PCD_DEC_FULL : PCD_DEC_LOW;

   generate
      if (KIND == PCD_DEC_FULL) begin : g_full
         localparam logic [CNT_W-1:0] MATCH_C = DEC_VAL[CNT_W-1:0];
         assign hit_o = (cnt_i == MATCH_C);
      end else begin : g_low
         localparam logic [DEC_BITS-1:0] MATCH_C = DEC_VAL[DEC_BITS-1:0];
         assign hit_o = (cnt_i[DEC_BITS-1:0] == MATCH_C);
      end
   endgenerate
endmodule

// File: rtl/pcd_jk_toggle.sv
module pcd_jk_toggle (
   input  logic clk,
   input  logic rst,
   input  logic pulse_i,
   output logic q_o
);
   logic q_q;
   logic j_in;
   logic k_in;
   logic q_d;

   always_comb begin
      j_in = pulse_i | q_q;
      k_in = pulse_i;
      q_d  = (j_in & ~q_q) | (~k_in & q_q);
   end

   always_ff @(posedge clk) begin
      if (rst) q_q <= 1'b0;
      else     q_q <= q_d;
   end

   assign q_o = q_q;
endmodule

// File: rtl/pcd_divider.sv
module pcd_divider #(
   parameter int CNT_W    = 4,
   parameter int LOAD_VAL = 3,
   parameter int TERM_VAL = 12,
   parameter int DEC_BITS = 3,
   parameter int DEC_VAL  = 7
) (
   input  logic             clk,
   input  logic             rst,
   output logic             div_clk_o,
   output logic             dec_pulse_o,
   output logic [CNT_W-1:0] count_o
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("pcd_divider: CNT_W out of range");
      end
      if (LOAD_VAL >= TERM_VAL || TERM_VAL > CNT_MAX) begin : g_bad_range
         $error("pcd_divider: load/terminal values invalid");
      end
      if (DEC_BITS < 1 || DEC_BITS > CNT_W) begin : g_bad_dec
         $error("pcd_divider: DEC_BITS invalid");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             hit;
   logic             q;

   pcd_counter #(
      .CNT_W    (CNT_W),
      .LOAD_VAL (LOAD_VAL),
      .TERM_VAL (TERM_VAL)
   ) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .cnt_o (cnt)
   );

   pcd_decode #(
      .CNT_W    (CNT_W),
      .DEC_BITS (DEC_BITS),
      .DEC_VAL  (DEC_VAL)
   ) u_dec (
      .cnt_i (cnt),
      .hit_o (hit)
   );

   pcd_jk_toggle u_jk (
      .clk     (clk),
      .rst     (rst),
      .pulse_i (hit),
      .q_o     (q)
   );

   assign count_o     = cnt;
   assign dec_pulse_o = hit;
   assign div_clk_o   = q;
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
   parameter int CNT_W    = 4,
   parameter int LOAD_VAL = 3,
   parameter int TERM_VAL = 12
) (
   input logic             clk,
   input logic             rst,
   input logic             div_clk_o,
   input logic             dec_pulse_o,
   input logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] LOAD_C = LOAD_VAL[CNT_W-1:0];
   localparam logic [CNT_W-1:0] TERM_C = TERM_VAL[CNT_W-1:0];

   logic [CNT_W-1:0] cnt_plus;
   assign cnt_plus = count_o + 1'b1;

   AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
      (count_o != TERM_C) |=> (count_o == $past(cnt_plus))); // R1
   AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (count_o == TERM_C) |=> (count_o == LOAD_C)); // R2
   AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
      dec_pulse_o |=> !dec_pulse_o); // R5
   AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      dec_pulse_o |=> (div_clk_o != $past(div_clk_o))); // R6
   AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !dec_pulse_o |=> $stable(div_clk_o)); // R7
   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (count_o == LOAD_C && !div_clk_o && !dec_pulse_o)); // R8
endmodule

bind pcd_divider pcd_checker #(
   .CNT_W    (CNT_W),
   .LOAD_VAL (LOAD_VAL),
   .TERM_VAL (TERM_VAL)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .div_clk_o   (div_clk_o),
   .dec_pulse_o (dec_pulse_o),
   .count_o     (count_o)
);

// File: tb/sim_pcd_divider.sv
`timescale 1ns/1ps
module sim_pcd_divider;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       div_clk, pulse;
   logic [3:0] cnt;
   logic       div1, pulse1;
   logic [3:0] cnt1;
   logic       rst_off = 1'b0;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pcd_divider u0 (.clk(clk), .rst(rst), .div_clk_o(div_clk),
                   .dec_pulse_o(pulse), .count_o(cnt));
   pcd_divider u1 (.clk(clk), .rst(rst_off), .div_clk_o(div1),
                   .dec_pulse_o(pulse1), .count_o(cnt1));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      int exp_cnt, exp_div, hi_cnt, prev1;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 count", cnt, 3);
      chk("R8 div", div_clk, 0);
      chk("R8 pulse", pulse, 0);
      rst = 1'b0;
      hi_cnt = 0;
      for (int n = 1; n <= 205; n++) begin
         @(negedge clk);
         exp_cnt = 3 + (n % 10);
         exp_div = ((n + 5) / 10) % 2;
         chk((exp_cnt == 3) ? "R2 reload" : "R1 R3 count", cnt, exp_cnt);
         chk("R5 pulse", pulse, (exp_cnt == 7) ? 1 : 0);
         chk((n % 10 == 5) ? "R6 toggle" : "R7 R9 hold", div_clk, exp_div);
         if (n >= 5 && n < 185) hi_cnt += div_clk;
         if (n == 5) chk("R9 first rise", div_clk, 1);
      end
      // R10: 9 windows of 20 clocks from edge 5, each 10 high
      chk("R10 duty", hi_cnt, 90);
      // R4: unreset instance must be in range after 16 edges
      prev1 = cnt1;
      chk("R4 range", ((cnt1 >= 3) && (cnt1 <= 12)) ? 1 : 0, 1);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk("R4 sequence", cnt1, (prev1 == 12) ? 3 : prev1 + 1);
         prev1 = cnt1;
      end
      // R8: reset mid-run
      rst = 1'b1;
      @(negedge clk);
      chk("R8 mid count", cnt, 3);
      chk("R8 mid div", div_clk, 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule